// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Deferred Compare Load

This block produces one pulse-width-modulated signal and its inverse from a triangle counter. The counter climbs from zero to a programmable top value, falls back to zero and repeats, so one period lasts twice the top value in clocks. A compare value sets the pulse width. While the counter climbs, reaching the compare value turns the output active. While it falls, reaching the compare value turns the output inactive. The active interval therefore sits symmetrically around the counter peak.

The compare value is written through a single-cycle write strobe. A mode input decides where a write goes. It either replaces the working compare at once, or it goes to a holding register that is copied into the working compare on the cycle the counter sits at zero. The level applied at that zero cycle is computed from the value being copied in that same cycle. A compare of zero therefore yields an output that is active for every clock of the period, and a compare at or above the top value yields an output that is never active. A top value of 833 at an 80 MHz clock gives a period near 48 kHz.

Top module: `cpwm_core`

## Requirements
- R1: The count in `cnt_o` runs 0,1,…,L,L-1,…,1 and repeats, where L is `load_val`, for a period of 2L clocks. `cnt_up_o` is 1 for the values 0 to L and 0 for the values L-1 down to 1.
- R2: With `cmp_defer`=0, a write takes effect from the next counter value onward, within the current period.
- R3: With `cmp_defer`=1, a write leaves the period in progress unchanged and takes effect from the next zero count.
- R4: If several writes occur with `cmp_defer`=1 between two zero counts, only the last one is used from the next zero count.
- R5: A compare of 0 keeps the output active for all 2L clocks of the period, with no edge.
- R6: A compare greater than or equal to L keeps the output inactive for the whole period. The reset value of the compare is all ones.
- R7: For a compare C with 0 < C < L, the output is active for exactly 2(L-C) clocks per period, as one contiguous interval with one rising and one falling edge.
- R8: `pol_inv`=0 makes the active level of `pwm_out` high. `pol_inv`=1 makes it low.
- R9: `pwm_out_n` is always the inverse of `pwm_out`. After reset `pwm_out` is inactive and the count is 0.
- R10: With `cmp_defer`=0, a write that lands after the climbing match of the current period causes no extra edge. The new value acts at the next falling crossing, giving (L-Cold)+(L-Cnew) active clocks in that period.
- R11: The level set at the zero count follows the compare loaded in that same cycle. Changing from a nonzero compare to 0 gives a full active period at once, and changing from 0 to a nonzero compare gives a correct partial period at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_val | input | CNT_W | Top value L of the triangle count |
| cmp_wr_en | input | 1 | One-cycle compare write strobe |
| cmp_wr_data | input | CNT_W | Compare value to write |
| cmp_defer | input | 1 | 1: hold the write until the zero count, 0: apply at once |
| pol_inv | input | 1 | 1: output is active low |
| cnt_o | output | CNT_W | Current count |
| cnt_up_o | output | 1 | 1 while the count is in its climbing half |
| pwm_out | output | 1 | Main PWM output |
| pwm_out_n | output | 1 | Complementary PWM output |

## Verification
The hardest cases to reach are those where the compare value changes close to the events that act on it. One is a deferred write that turns the compare from nonzero to zero, or from zero back to nonzero, exactly at the zero count. The other is an immediate write that lands after the output has already risen. The bench reaches both by locking onto the zero count through `cnt_o` and then placing a single write strobe at a chosen clock offset inside the following period. Over that period it counts active clocks and edges and compares them with the closed-form duty (L-Cold)+(L-Cnew) or 2(L-C).

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        UPD_NOW     = 1'b0,
        UPD_AT_ZERO = 1'b1
    } upd_mode_e;

    // events that may move the output level in one cycle
    typedef struct packed {
        logic zero;
        logic set;
        logic clr;
    } hit_s;

    // zero event has top priority, it carries the level of the new compare
    function automatic logic resolve_level(hit_s h, logic zero_level, logic cur);
        if (h.zero) return zero_level;
        if (h.set)  return 1'b1;
        if (h.clr)  return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] cnt,
    output cnt_dir_e         dir,
    output logic             zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (load == '0) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (dir == DIR_UP) begin
            if (cnt >= load) begin
                cnt <= cnt - ONE;
                dir <= (cnt == ONE) ? DIR_UP : DIR_DOWN;
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            cnt <= cnt - ONE;
            if (cnt == ONE) dir <= DIR_UP;
        end
    end

    assign zero = (cnt == '0);

    // R1: climbing half steps by one
    a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_UP && cnt < load) |=> (cnt == $past(cnt) + ONE));

    // R1: falling half steps down by one
    a_r1_step_down: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_DOWN && load != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/cpwm_cmp_shadow.sv
module cpwm_cmp_shadow
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  upd_mode_e        mode,
    input  logic             zero,
    output logic [CNT_W-1:0] c_eff
);

    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cmp_hold;
    logic             hold_valid;

    // value in force this cycle: at the zero count a pending value is
    // already the one that decides the output
    always_comb begin
        c_eff = (zero && hold_valid) ? cmp_hold : cmp_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act    <= '1;
            cmp_hold   <= '1;
            hold_valid <= 1'b0;
        end else begin
            if (zero) begin
                cmp_act    <= c_eff;
                hold_valid <= 1'b0;
            end
            if (wr_en) begin
                if (mode == UPD_AT_ZERO) begin
                    cmp_hold   <= wr_data;
                    hold_valid <= 1'b1;
                end else begin
                    cmp_act    <= wr_data;
                    hold_valid <= 1'b0;
                end
            end
        end
    end

    // R3: working compare moves only at zero or on an immediate write
    a_r3_act_only_at_zero: assert property (@(posedge clk) disable iff (rst)
        (!zero && !(wr_en && mode == UPD_NOW)) |=> $stable(cmp_act));

    // R4: a held value is never dropped before the zero count
    a_r4_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && !zero && !(wr_en && mode == UPD_NOW)) |=> hold_valid);

endmodule

// File: rtl/cpwm_edge_out.sv
module cpwm_edge_out
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  cnt_dir_e         dir,
    input  logic             zero,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] c_eff,
    output logic             active_q
);

    hit_s hits;
    logic zero_level;

    always_comb begin
        hits.zero  = zero;
        hits.set   = (dir == DIR_UP)   && (cnt == c_eff) && (c_eff < load);
        hits.clr   = (dir == DIR_DOWN) && (cnt == c_eff);
        zero_level = (c_eff == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= resolve_level(hits, zero_level, active_q);
    end

    // R10: the level only moves on a zero count or a compare crossing
    a_r10_edge_on_event: assert property (@(posedge clk) disable iff (rst)
        (active_q != $past(active_q)) |->
            ($past(zero) || ($past(cnt) == $past(c_eff))));

    // R5: compare zero at the zero count turns the output active
    a_r5_full_duty: assert property (@(posedge clk) disable iff (rst)
        (zero && c_eff == '0) |=> active_q);

    // R6: compare at or above top leaves the period inactive from zero on
    a_r6_empty_duty: assert property (@(posedge clk) disable iff (rst)
        (zero && c_eff != '0 && c_eff >= load) |=> !active_q);

endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             cmp_defer,
    input  logic             pol_inv,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_up_o,
    output logic             pwm_out,
    output logic             pwm_out_n
);

    logic [CNT_W-1:0] cnt;
    cnt_dir_e         dir;
    logic             zero;
    logic [CNT_W-1:0] c_eff;
    logic             active_q;

    cpwm_tri_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load_val),
        .cnt  (cnt),
        .dir  (dir),
        .zero (zero)
    );

    cpwm_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .mode    (upd_mode_e'(cmp_defer)),
        .zero    (zero),
        .c_eff   (c_eff)
    );

    cpwm_edge_out #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .dir      (dir),
        .zero     (zero),
        .load     (load_val),
        .c_eff    (c_eff),
        .active_q (active_q)
    );

    assign cnt_o     = cnt;
    assign cnt_up_o  = (dir == DIR_UP);
    assign pwm_out   = active_q ^ pol_inv;
    assign pwm_out_n = ~pwm_out;

endmodule

// File: tb/test_cpwm_core.sv
`timescale 1ns/1ps
module test_cpwm_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] load_val;
    logic        cmp_wr_en;
    logic [15:0] cmp_wr_data;
    logic        cmp_defer;
    logic        pol_inv;
    logic [15:0] cnt_o;
    logic        cnt_up_o;
    logic        pwm_out;
    logic        pwm_out_n;

    int n_chk = 0;
    int n_bad = 0;
    int lcur  = 20;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cpwm_core #(.CNT_W(16)) i_cpwm_core (
        .clk (clk), .rst (rst), .load_val (load_val),
        .cmp_wr_en (cmp_wr_en), .cmp_wr_data (cmp_wr_data),
        .cmp_defer (cmp_defer), .pol_inv (pol_inv),
        .cnt_o (cnt_o), .cnt_up_o (cnt_up_o),
        .pwm_out (pwm_out), .pwm_out_n (pwm_out_n)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int exp_act(int c, int l);
        if (c == 0) return 2 * l;
        if (c >= l) return 0;
        return 2 * (l - c);
    endfunction

    task automatic do_reset(int l);
        @(negedge clk);
        rst = 1'b1; load_val = 16'(l); lcur = l;
        cmp_wr_en = 1'b0; cmp_wr_data = '0; cmp_defer = 1'b0; pol_inv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cmp_write(int val, bit defer);
        @(negedge clk);
        cmp_defer = defer; cmp_wr_data = 16'(val); cmp_wr_en = 1'b1;
        @(negedge clk);
        cmp_wr_en = 1'b0;
    endtask

    // one full period starting after a zero count; optional write at index wi
    task automatic measure(int wi, int wv, output int act_n, output int raw_hi,
                           output int edges, output int comp_bad);
        logic prev = 1'b0;
        act_n = 0; raw_hi = 0; edges = 0; comp_bad = 0;
        do @(negedge clk); while (cnt_o != 16'd0);
        for (int i = 0; i < 2 * lcur; i++) begin
            @(negedge clk);
            cmp_wr_en = 1'b0;
            if (pwm_out ^ pol_inv) act_n++;
            if (pwm_out) raw_hi++;
            if (pwm_out_n !== ~pwm_out) comp_bad++;
            if (i > 0 && pwm_out != prev) edges++;
            prev = pwm_out;
            if (i == wi) begin
                cmp_wr_data = 16'(wv);
                cmp_wr_en = 1'b1;
            end
        end
        @(negedge clk);
        cmp_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        int a, h, e, cb;
        do_reset(20);
        @(negedge clk);
        chk("R9 reset pwm_out", int'(pwm_out), 0);
        chk("R9 reset pwm_out_n", int'(pwm_out_n), 1);
        measure(-1, 0, a, h, e, cb);
        chk("R6 reset compare gives no active clock", a, 0);
        chk("R9 complement", cb, 0);
    endtask

    task automatic t_duty();
        int a, h, e, cb;
        int vals[4] = '{5, 13, 1, 19};
        foreach (vals[k]) begin
            cmp_write(vals[k], 1'b0);
            measure(-1, 0, a, h, e, cb);
            chk($sformatf("R7 active clocks C=%0d", vals[k]), a, exp_act(vals[k], lcur));
            chk($sformatf("R7 edges C=%0d", vals[k]), e, 2);
            chk("R9 complement", cb, 0);
        end
    endtask

    task automatic t_extremes();
        int a, h, e, cb;
        cmp_write(0, 1'b0);
        measure(-1, 0, a, h, e, cb);
        chk("R5 compare 0 immediate active", a, 2 * lcur);
        chk("R5 compare 0 no edge", e, 0);
        cmp_write(20, 1'b1);
        measure(-1, 0, a, h, e, cb);
        chk("R6 compare L inactive", a, 0);
        cmp_write(25, 1'b0);
        measure(-1, 0, a, h, e, cb);
        chk("R6 compare above L inactive", a, 0);
        chk("R6 no edge", e, 0);
    endtask

    task automatic t_immediate();
        int a, h, e, cb;
        cmp_write(5, 1'b0);
        measure(0, 15, a, h, e, cb);
        chk("R2 immediate write applies this period", a, exp_act(15, lcur));
        measure(-1, 0, a, h, e, cb);
        chk("R2 value kept next period", a, exp_act(15, lcur));
    endtask

    task automatic t_deferred();
        int a, h, e, cb;
        cmp_write(5, 1'b1);
        measure(0, 15, a, h, e, cb);
        chk("R3 deferred write leaves period unchanged", a, exp_act(5, lcur));
        measure(-1, 0, a, h, e, cb);
        chk("R3 deferred value after zero", a, exp_act(15, lcur));
    endtask

    task automatic t_last_wins();
        int a, h, e, cb;
        do @(negedge clk); while (cnt_o != 16'd3);
        cmp_write(3, 1'b1);
        cmp_write(17, 1'b1);
        cmp_write(9, 1'b1);
        measure(-1, 0, a, h, e, cb);
        chk("R4 last deferred write used", a, exp_act(9, lcur));
    endtask

    task automatic t_zero_load();
        int a, h, e, cb;
        cmp_write(5, 1'b1);
        measure(-1, 0, a, h, e, cb);
        cmp_write(0, 1'b1);
        measure(-1, 0, a, h, e, cb);
        chk("R11 nonzero to 0 full period", a, 2 * lcur);
        chk("R11 nonzero to 0 no glitch", e, 0);
        cmp_write(8, 1'b1);
        measure(-1, 0, a, h, e, cb);
        chk("R11 0 to 8 partial period", a, exp_act(8, lcur));
        chk("R11 0 to 8 edges", e, 2);
    endtask

    task automatic t_late_write();
        int a, h, e, cb;
        cmp_write(5, 1'b0);
        measure(11, 15, a, h, e, cb);
        chk("R10 late immediate write active clocks", a, (lcur - 5) + (lcur - 15));
        chk("R10 late immediate write edges", e, 2);
    endtask

    task automatic t_polarity();
        int a, h, e, cb;
        pol_inv = 1'b1;
        cmp_write(5, 1'b0);
        measure(-1, 0, a, h, e, cb);
        chk("R8 inverted active clocks", a, exp_act(5, lcur));
        chk("R8 inverted raw high clocks", h, 2 * lcur - exp_act(5, lcur));
        chk("R9 complement inverted", cb, 0);
        pol_inv = 1'b0;
    endtask

    task automatic t_counter();
        int bad_c = 0, bad_d = 0, mx = 0, a, h, e, cb;
        do_reset(833);
        for (int t = 1; t <= 4 * 833; t++) begin
            int k, ec;
            bit eu;
            @(negedge clk);
            k  = t % (2 * 833);
            ec = (k <= 833) ? k : 2 * 833 - k;
            eu = (k <= 833);
            if (int'(cnt_o) != ec) bad_c++;
            if (cnt_up_o != eu) bad_d++;
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
        end
        chk("R1 count sequence", bad_c, 0);
        chk("R1 direction flag", bad_d, 0);
        chk("R1 peak equals load", mx, 833);
        cmp_write(416, 1'b1);
        measure(-1, 0, a, h, e, cb);
        chk("R7 duty at load 833", a, exp_act(416, 833));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_val = 16'd20; cmp_wr_en = 1'b0; cmp_wr_data = '0;
        cmp_defer = 1'b0; pol_inv = 1'b0;
        t_reset();
        t_duty();
        t_extremes();
        t_immediate();
        t_deferred();
        t_last_wins();
        t_zero_load();
        t_late_write();
        t_polarity();
        t_counter();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule